// File: doc/BRIEF.md
# Priority-Arbitrated Shared Memory Port

This block connects three client ports to one downstream memory port. Every client request carries an address and a write flag. When the flag is set, the request is a write and carries a data word. When the flag is clear, the request is a read. A fixed-priority picker selects one eligible client and the block forwards that client's request downstream. Writes complete silently. Read data coming back from memory is routed to the client that issued the read. It is held in that client's own one-entry buffer until the client takes it.

Only one request is in flight downstream at a time. After a read has been forwarded, no new client request is accepted until the memory's reply has been captured. A client whose buffer still holds unread data is not granted another read. That client therefore never holds up the other clients, and clients may take their data in any order. The memory array itself lies outside the block. Client requests, client responses, the downstream request and the downstream response all use valid/ready handshakes.

Top module: `shared_mem_arbiter`

## Requirements
- R1: A request whose write flag is 1 is a write carrying its data word. A request whose write flag is 0 is a read. The forwarded downstream request carries the accepted client's address, write flag and data unchanged.
- R2: An accepted write produces no response on any client port.
- R3: Each accepted read produces exactly one response. The response appears only on the port that issued the read and carries the data word the memory returned.
- R4: At most one client is accepted per cycle, and only one that presents a valid request. Among eligible clients, port 0 wins over port 1, and port 1 wins over port 2.
- R5: Each client has a one-entry response buffer. A client whose buffer is full is not accepted for a read, while other clients are still accepted and served.
- R6: A client whose response buffer is full can still have a write accepted.
- R7: Buffered responses may be taken in any order across clients. A response holds its valid and data stable until it is taken.
- R8: The downstream request holds its valid, address, write flag and data stable until the memory accepts it.
- R9: At most one read is outstanding downstream. While a read response is awaited, the downstream response ready is high and no client request is accepted.
- R10: After reset, no client response is valid, no downstream request is valid, the downstream response ready is low and no client is accepted until a request is presented.
- R11: A write followed by a read of the same address, from any ports, returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_req_valid | input | NCLI | Per-client request valid |
| cli_req_ready | output | NCLI | Per-client request accepted this cycle |
| cli_req_addr | input | NCLI*AW | Per-client address, client i in bits [i*AW +: AW] |
| cli_req_wr | input | NCLI | Per-client write flag (1 = write with data, 0 = read) |
| cli_req_wdata | input | NCLI*DW | Per-client write data, client i in bits [i*DW +: DW] |
| cli_rsp_valid | output | NCLI | Per-client buffered read data valid |
| cli_rsp_ready | input | NCLI | Per-client read data taken |
| cli_rsp_data | output | NCLI*DW | Per-client read data, client i in bits [i*DW +: DW] |
| mem_req_valid | output | 1 | Downstream request valid |
| mem_req_ready | input | 1 | Downstream request accepted |
| mem_req_addr | output | AW | Downstream address |
| mem_req_wr | output | 1 | Downstream write flag |
| mem_req_wdata | output | DW | Downstream write data |
| mem_rsp_valid | input | 1 | Downstream read data valid |
| mem_rsp_ready | output | 1 | Block awaiting downstream read data |
| mem_rsp_data | input | DW | Downstream read data |

## Verification
The hardest state to reach from the ports is a full buffer on a higher-priority client while lower-priority clients compete. In that state a read from the full client must be passed over and a write from it must still be taken. The directed stimulus holds the response ready of port 0 low until its buffer fills. It then presents mixed reads and writes on several ports at once and takes the buffered responses back in reverse port order. A long random phase follows. It adds randomly stalled memory handshakes and randomly withheld response readies over a small address range, so writes and reads to the same addresses interleave across ports.

// File: rtl/mpa_pkg.sv
`timescale 1ns/1ps
package mpa_pkg;
  // issue controller phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // may accept a client request
    ST_SEND = 2'd1,   // downstream request presented, waiting for ready
    ST_WAIT = 2'd2    // read forwarded, waiting for returned data
  } mpa_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mpa_prio_pick.sv
`timescale 1ns/1ps
module mpa_prio_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest index wins
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_gnt
      if (g == 0) begin : g_first
        assign gnt[g] = req[g];
      end else begin : g_rest
        assign gnt[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/mpa_rsp_slot.sv
`timescale 1ns/1ps
module mpa_rsp_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (cap_en) begin
      full_q <= 1'b1;
    end else if (full_q && out_ready) begin
      full_q <= 1'b0;
    end
  end

  // data path without reset so it maps onto plain registers
  always_ff @(posedge clk) begin
    if (cap_en) data_q <= cap_data;
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/mpa_issue_ctl.sv
`timescale 1ns/1ps
module mpa_issue_ctl import mpa_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pick_any,
  input  logic [IW-1:0] pick_idx,
  input  logic [AW-1:0] sel_addr,
  input  logic          sel_wr,
  input  logic [DW-1:0] sel_wdata,
  output logic          idle,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_wr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  output logic          cap_en,
  output logic [IW-1:0] owner
);
  mpa_state_e    state_q;
  logic          req_v_q;
  logic          rsp_r_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic [IW-1:0] owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_v_q <= 1'b0;
      rsp_r_q <= 1'b0;
      owner_q <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pick_any) begin
            addr_q  <= sel_addr;
            wr_q    <= sel_wr;
            wdata_q <= sel_wdata;
            owner_q <= pick_idx;
            req_v_q <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (mem_req_ready) begin
            req_v_q <= 1'b0;
            if (wr_q) begin
              state_q <= ST_IDLE;
            end else begin
              rsp_r_q <= 1'b1;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_r_q <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle          = (state_q == ST_IDLE);
  assign cap_en        = (state_q == ST_WAIT) && mem_rsp_valid;
  assign owner         = owner_q;
  assign mem_req_valid = req_v_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wr    = wr_q;
  assign mem_req_wdata = wdata_q;
  assign mem_rsp_ready = rsp_r_q;
endmodule

// File: rtl/shared_mem_arbiter.sv
`timescale 1ns/1ps
module shared_mem_arbiter import mpa_pkg::*; #(
  parameter int NCLI = 3,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCLI-1:0]    cli_req_valid,
  output logic [NCLI-1:0]    cli_req_ready,
  input  logic [NCLI*AW-1:0] cli_req_addr,
  input  logic [NCLI-1:0]    cli_req_wr,
  input  logic [NCLI*DW-1:0] cli_req_wdata,
  output logic [NCLI-1:0]    cli_rsp_valid,
  input  logic [NCLI-1:0]    cli_rsp_ready,
  output logic [NCLI*DW-1:0] cli_rsp_data,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  output logic               mem_req_wr,
  output logic [DW-1:0]      mem_req_wdata,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [DW-1:0]      mem_rsp_data
);
  localparam int IW = idx_width(NCLI);

  logic [NCLI-1:0] slot_full;
  logic [NCLI-1:0] eligible;
  logic [NCLI-1:0] gnt;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic            idle;
  logic            cap_en;
  logic [IW-1:0]   owner;
  logic [AW-1:0]   sel_addr;
  logic            sel_wr;
  logic [DW-1:0]   sel_wdata;

  // reads need a free buffer, writes never do
  assign eligible = cli_req_valid & (cli_req_wr | ~slot_full);

  mpa_prio_pick #(.N(NCLI), .IW(IW)) u_pick (
    .req (eligible),
    .gnt (gnt),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign cli_req_ready = idle ? gnt : '0;

  // one-hot OR mux of the granted request
  always_comb begin
    sel_addr  = '0;
    sel_wr    = 1'b0;
    sel_wdata = '0;
    for (int i = 0; i < NCLI; i++) begin
      if (gnt[i]) begin
        sel_addr  = sel_addr  | cli_req_addr[i*AW +: AW];
        sel_wr    = sel_wr    | cli_req_wr[i];
        sel_wdata = sel_wdata | cli_req_wdata[i*DW +: DW];
      end
    end
  end

  mpa_issue_ctl #(.AW(AW), .DW(DW), .IW(IW)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .pick_any      (pick_any),
    .pick_idx      (pick_idx),
    .sel_addr      (sel_addr),
    .sel_wr        (sel_wr),
    .sel_wdata     (sel_wdata),
    .idle          (idle),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wr    (mem_req_wr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .cap_en        (cap_en),
    .owner         (owner)
  );

  genvar g;
  generate
    for (g = 0; g < NCLI; g++) begin : g_slot
      logic cap_here;
      assign cap_here = cap_en && (owner == IW'(g));
      mpa_rsp_slot #(.DW(DW)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_here),
        .cap_data  (mem_rsp_data),
        .out_valid (slot_full[g]),
        .out_ready (cli_rsp_ready[g]),
        .out_data  (cli_rsp_data[g*DW +: DW])
      );
    end
  endgenerate

  assign cli_rsp_valid = slot_full;
endmodule

// File: rtl/shared_mem_arbiter_chk.sv
`timescale 1ns/1ps
module shared_mem_arbiter_chk #(
  parameter int NCLI = 3,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NCLI-1:0]    cli_req_valid,
  input logic [NCLI-1:0]    cli_req_ready,
  input logic [NCLI-1:0]    cli_req_wr,
  input logic [NCLI-1:0]    cli_rsp_valid,
  input logic [NCLI-1:0]    cli_rsp_ready,
  input logic [NCLI*DW-1:0] cli_rsp_data,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [AW-1:0]      mem_req_addr,
  input logic               mem_req_wr,
  input logic [DW-1:0]      mem_req_wdata,
  input logic               mem_rsp_ready
);
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cli_req_ready)); // R4

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (cli_req_ready & ~cli_req_valid) == '0); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wr) && $stable(mem_req_wdata))); // R8

  AST_NO_ACCEPT_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_ready |-> (cli_req_ready == '0)); // R9

  AST_NO_REQ_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_ready |-> !mem_req_valid); // R9

  genvar g;
  generate
    for (g = 0; g < NCLI; g++) begin : g_cli
      AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (cli_rsp_valid[g] && !cli_rsp_ready[g]) |=>
          (cli_rsp_valid[g] && $stable(cli_rsp_data[g*DW +: DW]))); // R7

      AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (cli_rsp_valid[g] && !cli_req_wr[g]) |-> !cli_req_ready[g]); // R5
    end
  endgenerate
endmodule

bind shared_mem_arbiter shared_mem_arbiter_chk #(.NCLI(NCLI), .AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cli_req_valid (cli_req_valid),
  .cli_req_ready (cli_req_ready),
  .cli_req_wr    (cli_req_wr),
  .cli_rsp_valid (cli_rsp_valid),
  .cli_rsp_ready (cli_rsp_ready),
  .cli_rsp_data  (cli_rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wr    (mem_req_wr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/shared_mem_arbiter_test.sv
`timescale 1ns/1ps
module shared_mem_arbiter_test;
  localparam int NCLI = 3;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int MD   = 1 << AW;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NCLI-1:0]    cli_req_valid = '0;
  logic [NCLI-1:0]    cli_req_ready;
  logic [NCLI*AW-1:0] cli_req_addr = '0;
  logic [NCLI-1:0]    cli_req_wr = '0;
  logic [NCLI*DW-1:0] cli_req_wdata = '0;
  logic [NCLI-1:0]    cli_rsp_valid;
  logic [NCLI-1:0]    cli_rsp_ready = '0;
  logic [NCLI*DW-1:0] cli_rsp_data;
  logic               mem_req_valid;
  logic               mem_req_ready = 1'b0;
  logic [AW-1:0]      mem_req_addr;
  logic               mem_req_wr;
  logic [DW-1:0]      mem_req_wdata;
  logic               mem_rsp_valid = 1'b0;
  logic               mem_rsp_ready;
  logic [DW-1:0]      mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  shared_mem_arbiter #(.NCLI(NCLI), .AW(AW), .DW(DW)) uut (.*);

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // memory model and scoreboard state
  logic [DW-1:0] model_mem [MD];
  logic [DW-1:0] ref_mem   [MD];
  bit            rsp_pend = 1'b0;
  logic [DW-1:0] pend_data = '0;
  int            req_mode = 1;  // 0 random, 1 always ready, 2 never ready
  int            rsp_mode = 1;  // 0 random, 1 always valid, 2 withheld
  bit            rand_cli = 1'b0;
  bit            rand_take = 1'b0;
  bit            exp_v [NCLI];
  logic [DW-1:0] exp_d [NCLI];
  bit [NCLI-1:0] acc_flag = '0;
  logic [NCLI-1:0] smp_ready = '0;
  int            acc_log [16];
  int            acc_n = 0;
  int            hs_n = 0;
  logic [AW-1:0] hs_addr = '0;
  logic          hs_wr = 1'b0;
  logic [DW-1:0] hs_wdata = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int i, input bit wr, input int a, input int d);
    cli_req_valid[i]           = 1'b1;
    cli_req_wr[i]              = wr;
    cli_req_addr[i*AW +: AW]   = AW'(a);
    cli_req_wdata[i*DW +: DW]  = DW'(d);
  endtask

  // one clock: sample before the edge, then drive after the falling edge
  task automatic tick();
    #1;
    smp_ready = cli_req_ready;
    for (int i = 0; i < NCLI; i++) begin
      if (cli_rsp_valid[i] && cli_rsp_ready[i]) begin
        check(exp_v[i], $sformatf("R2/R3 unexpected response on port %0d", i), 1, exp_v[i]);
        check(cli_rsp_data[i*DW +: DW] == exp_d[i], $sformatf("R11 read data port %0d", i),
              cli_rsp_data[i*DW +: DW], exp_d[i]);
        exp_v[i] = 1'b0;
      end
    end
    for (int i = 0; i < NCLI; i++) begin
      if (cli_req_valid[i] && cli_req_ready[i]) begin
        acc_flag[i] = 1'b1;
        if (acc_n < 16) acc_log[acc_n] = i;
        acc_n++;
        if (cli_req_wr[i]) begin
          ref_mem[cli_req_addr[i*AW +: AW]] = cli_req_wdata[i*DW +: DW];
        end else begin
          check(!exp_v[i], "R5 read accepted with full buffer", 1, 0);
          exp_v[i] = 1'b1;
          exp_d[i] = ref_mem[cli_req_addr[i*AW +: AW]];
        end
      end
    end
    if (mem_rsp_valid && mem_rsp_ready) rsp_pend = 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      hs_n++;
      hs_addr  = mem_req_addr;
      hs_wr    = mem_req_wr;
      hs_wdata = mem_req_wdata;
      if (mem_req_wr) begin
        model_mem[mem_req_addr] = mem_req_wdata;
      end else begin
        rsp_pend  = 1'b1;
        pend_data = model_mem[mem_req_addr];
      end
    end
    @(negedge clk);
    for (int i = 0; i < NCLI; i++) if (acc_flag[i]) cli_req_valid[i] = 1'b0;
    acc_flag = '0;
    mem_req_ready = (req_mode == 0) ? 1'($urandom_range(1)) : (req_mode == 1);
    mem_rsp_valid = rsp_pend && ((rsp_mode == 0) ? 1'($urandom_range(1)) : (rsp_mode == 1));
    mem_rsp_data  = rsp_pend ? pend_data : DW'($urandom);
    if (rand_take) cli_rsp_ready = NCLI'($urandom);
    if (rand_cli) begin
      for (int i = 0; i < NCLI; i++) begin
        if (!cli_req_valid[i] && $urandom_range(2) == 0)
          drive(i, 1'($urandom_range(1)), $urandom_range(7), $urandom);
      end
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wait_accept(output logic [NCLI-1:0] got);
    got = '0;
    for (int k = 0; k < 50 && got == '0; k++) begin
      tick();
      got = smp_ready;
    end
  endtask

  task automatic drain();
    rand_cli = 1'b0;
    rand_take = 1'b0;
    cli_rsp_ready = '1;
    req_mode = 1;
    rsp_mode = 1;
    for (int k = 0; k < 400; k++) begin
      if (cli_req_valid == '0 && !rsp_pend && !mem_req_valid && !mem_rsp_ready &&
          cli_rsp_valid == '0 && !exp_v[0] && !exp_v[1] && !exp_v[2]) break;
      tick();
    end
    check(!exp_v[0] && !exp_v[1] && !exp_v[2], "R3 every read answered",
          {exp_v[2], exp_v[1], exp_v[0]}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [NCLI-1:0] got;
    void'($urandom(32'h5eed_0042));
    for (int a = 0; a < MD; a++) begin
      model_mem[a] = DW'(a * 7 + 3);
      ref_mem[a]   = DW'(a * 7 + 3);
    end
    for (int i = 0; i < NCLI; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mem_req_ready = 1'b1;
    run(2);

    // R10 reset state
    check(cli_rsp_valid == '0, "R10 rsp valid after reset", cli_rsp_valid, 0);
    check(!mem_req_valid, "R10 mem req valid after reset", mem_req_valid, 0);
    check(!mem_rsp_ready, "R10 mem rsp ready after reset", mem_rsp_ready, 0);
    check(smp_ready == '0, "R10 no accept without request", smp_ready, 0);

    // R1/R2: write from port 2, forwarded intact, no response
    drive(2, 1'b1, 5, 16'hBEEF);
    run(6);
    check(hs_n == 1 && hs_wr && hs_addr == 5 && hs_wdata == 16'hBEEF,
          "R1 forwarded write fields", {hs_wr, hs_addr, hs_wdata}, {1'b1, 6'd5, 16'hBEEF});
    check(cli_rsp_valid == '0, "R2 no response after write", cli_rsp_valid, 0);

    // R1/R11: read back from port 0
    cli_rsp_ready = '1;
    drive(0, 1'b0, 5, 0);
    run(8);
    check(!hs_wr && hs_addr == 5, "R1 forwarded read fields", {hs_wr, hs_addr}, {1'b0, 6'd5});
    check(!exp_v[0], "R11 read after write delivered", exp_v[0], 0);

    // R8: downstream never ready, request held
    req_mode = 2;
    run(1);
    drive(1, 1'b1, 9, 16'h1234);
    run(6);
    check(mem_req_valid && mem_req_addr == 9 && mem_req_wdata == 16'h1234,
          "R8 request held while stalled", {mem_req_valid, mem_req_addr}, {1'b1, 6'd9});
    req_mode = 1;
    run(3);
    check(model_mem[9] == 16'h1234, "R8 write delivered after stall", model_mem[9], 16'h1234);

    // R9: read awaiting data blocks new accepts
    rsp_mode = 2;
    drive(0, 1'b0, 9, 0);
    run(4);
    drive(1, 1'b1, 10, 16'h0A0A);
    run(5);
    check(mem_rsp_ready && cli_req_valid[1], "R9 no accept while read outstanding",
          {mem_rsp_ready, cli_req_valid[1]}, 2'b11);
    rsp_mode = 1;
    drain();

    // R4/R5/R7: three reads, buffers not taken
    cli_rsp_ready = '0;
    acc_n = 0;
    drive(0, 1'b0, 1, 0);
    drive(1, 1'b0, 2, 0);
    drive(2, 1'b0, 3, 0);
    wait_accept(got);
    check(got == 3'b001, "R4 port 0 wins", got, 3'b001);
    run(20);
    check(acc_n == 3 && acc_log[1] == 1 && acc_log[2] == 2, "R4 grant order 0,1,2",
          {acc_log[1], acc_log[2]}, {32'd1, 32'd2});
    check(cli_rsp_valid == 3'b111, "R5 others served while port 0 full", cli_rsp_valid, 3'b111);
    cli_rsp_ready = 3'b100;
    run(1);
    cli_rsp_ready = '0;
    run(2);
    check(cli_rsp_valid == 3'b011, "R7 port 2 taken first, others kept", cli_rsp_valid, 3'b011);
    cli_rsp_ready = 3'b010;
    run(1);
    cli_rsp_ready = '0;
    run(2);
    check(cli_rsp_valid == 3'b001, "R7 port 1 taken before port 0", cli_rsp_valid, 3'b001);

    // R6: port 0 full, its write still wins over port 1 read
    drive(0, 1'b1, 7, 16'h7777);
    drive(1, 1'b0, 7, 0);
    wait_accept(got);
    check(got == 3'b001, "R6 write accepted from full port", got, 3'b001);
    run(12);
    check(cli_rsp_valid == 3'b011, "R6 port 1 read served", cli_rsp_valid, 3'b011);
    // R5: full port 0 read passed over for port 2
    drive(0, 1'b0, 7, 0);
    drive(2, 1'b0, 7, 0);
    wait_accept(got);
    check(got == 3'b100, "R5 full port skipped for read", got, 3'b100);
    drain();

    // random phase
    req_mode = 0;
    rsp_mode = 0;
    rand_cli = 1'b1;
    rand_take = 1'b1;
    run(4000);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule